// File: doc/BRIEF.md
# Companion Chip Register File

This block is the 16-bit register bank of a companion chip that looks after keyboard, power and display settings. A host reaches it through a half-word port: one address, one write strobe, one read strobe. Besides plain storage for settings it carries an interrupt status/mask pair whose status drives a pulsing interrupt pin, a flag register that is armed by particular serial function codes and cleared when read, and a data port that streams bytes out of a small internal configuration memory.

Read data is registered. A read sampled on a rising edge puts its value on `rdData` after that edge, and `rdData` holds it until the next read. Side effects of a read (clearing the flag, advancing the stream pointer) take place on the same edge. The `tick` input is the block's slow time base: the interrupt reload and the pin toggling happen only on edges where `tick` is high.

Top module: `cmpn_regbank`

## Requirements
- R1: After reset every register, the stream pointer, `rdData` and `irqOut` are zero.
- R2: The word addresses 1 (keyboard address), 2 (power), 3 (contrast), 4 (brightness), 5 (keyboard scan), 6 (edge select) and 7 (interrupt mask) hold whatever was written, and a read returns it.
- R3: Address 0 (control) stores writes, but a read of it always returns zero.
- R4: Writing address 8 (interrupt status) clears each status bit written as one and leaves every other bit unchanged.
- R5: A read of address 9 (function flag) returns the flag and clears it to zero on the same edge. Writes to address 9 have no effect.
- R6: A write to address 10 (serial function code) stores the value, which reads back. Writing the code 4 or 6 also sets the function flag to 2; other codes leave it alone.
- R7: A read of address 11 (stream data) returns {byte[p+1], byte[p]}, then adds 2 to the pointer p. Byte i of the configuration memory holds (29*i + 53) mod 256.
- R8: The stream pointer wraps to zero after the last byte pair of the configuration memory.
- R9: On a `tick` edge where the mask has any bit of 0x6000 set, the mask is copied into the interrupt status. This copy wins over a write-clear on the same edge. Without such a bit, a tick leaves the status alone.
- R10: On each `tick` edge, `irqOut` inverts if the updated status is nonzero and goes low if it is zero. Between ticks it holds.
- R11: Reads of addresses 12 to 15 return zero, and writes there change nothing.
- R12: `rdData` holds its value on cycles without a read, including cycles with writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Time-base strobe for interrupt reload and pin toggling |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Registered read data |
| irqOut | output | 1 | Interrupt pin |

## Verification
The bench builds the block with an 8-byte configuration memory in place of the default 16. With that size the pointer wraps after four stream reads, so the reads on both sides of the wrap are checked against bytes the bench computes itself. The remaining parameters keep their defaults: a 4-bit address, so the unused addresses 12 to 15 can be reached, the 0x6000 reload mask, function codes 4 and 6, and flag value 2. These make the reload, the pin toggling and the flag behaviour reachable with short, hand-countable sequences.

// File: rtl/cmpn_pkg.sv
package cmpn_pkg;

  // Word addresses of the register bank
  localparam int ADR_CTRL    = 0;
  localparam int ADR_KBDADDR = 1;
  localparam int ADR_POWER   = 2;
  localparam int ADR_CONTRST = 3;
  localparam int ADR_BRIGHT  = 4;
  localparam int ADR_KBDSCAN = 5;
  localparam int ADR_EDGE    = 6;
  localparam int ADR_MASK    = 7;
  localparam int ADR_IRQSTAT = 8;
  localparam int ADR_FNFLAG  = 9;
  localparam int ADR_FNCODE  = 10;
  localparam int ADR_STREAM  = 11;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrKbdAddr;
    logic wrPower;
    logic wrContrast;
    logic wrBright;
    logic wrKbdScan;
    logic wrEdge;
    logic wrMask;
    logic clrIrq;
    logic wrFunc;
    logic popFlag;
    logic popStream;
    logic rdCap;
    logic tick;
  } strobes_t;

  // Contents of the configuration memory
  function automatic logic [7:0] cfgByte(input int idx);
    return 8'((idx * 29 + 53) % 256);
  endfunction

endpackage

// File: rtl/cmpn_ctrl.sv
module cmpn_ctrl
  import cmpn_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              statNextNz,
  output strobes_t          stb,
  output logic              irqOut
);

  logic pinQ;

  // Address decode into strobes
  always_comb begin
    stb       = '0;
    stb.tick  = tick;
    stb.rdCap = rdEn;
    if (wrEn) begin
      case (int'(addr))
        ADR_CTRL:    stb.wrCtrl     = 1'b1;
        ADR_KBDADDR: stb.wrKbdAddr  = 1'b1;
        ADR_POWER:   stb.wrPower    = 1'b1;
        ADR_CONTRST: stb.wrContrast = 1'b1;
        ADR_BRIGHT:  stb.wrBright   = 1'b1;
        ADR_KBDSCAN: stb.wrKbdScan  = 1'b1;
        ADR_EDGE:    stb.wrEdge     = 1'b1;
        ADR_MASK:    stb.wrMask     = 1'b1;
        ADR_IRQSTAT: stb.clrIrq     = 1'b1;
        ADR_FNCODE:  stb.wrFunc     = 1'b1;
        default: ;
      endcase
    end
    if (rdEn) begin
      case (int'(addr))
        ADR_FNFLAG: stb.popFlag   = 1'b1;
        ADR_STREAM: stb.popStream = 1'b1;
        default: ;
      endcase
    end
  end

  // Interrupt pin: alternate on each tick while status is pending
  always_ff @(posedge clk) begin
    if (!rstN)     pinQ <= 1'b0;
    else if (tick) pinQ <= statNextNz ? ~pinQ : 1'b0;
  end

  assign irqOut = pinQ;

endmodule

// File: rtl/cmpn_dp.sv
module cmpn_dp
  import cmpn_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          MEM_BYTES = 16,
  parameter logic [15:0] LOAD_MASK = 16'h6000,
  parameter logic [15:0] CODE_A    = 16'd4,
  parameter logic [15:0] CODE_B    = 16'd6,
  parameter logic [15:0] FLAG_VAL  = 16'd2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobes_t                     stb,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [15:0]                  wrData,
  output logic [15:0]                  rdData,
  output logic                         statNextNz,
  output logic [15:0]                  irqStatQ,
  output logic [15:0]                  maskQ,
  output logic [15:0]                  flagQ,
  output logic [15:0]                  ctrlQ,
  output logic [$clog2(MEM_BYTES)-1:0] ptrQ
);

  localparam int PTR_W = $clog2(MEM_BYTES);

  logic [15:0] kbdAddrQ, powerQ, contrastQ, brightQ, kbdScanQ, edgeQ, funcQ;
  logic [15:0] rdDataQ, rdValue, statNext;
  logic [7:0]  cfgMem [MEM_BYTES];
  logic [PTR_W-1:0] ptrHi;

  // Configuration memory contents
  for (genvar g = 0; g < MEM_BYTES; g++) begin : g_cfg
    assign cfgMem[g] = cfgByte(g);
  end

  assign ptrHi = PTR_W'(ptrQ + PTR_W'(1));

  // Next interrupt status: a tick reload takes priority over a write-clear
  always_comb begin
    if (stb.tick && |(maskQ & LOAD_MASK)) statNext = maskQ;
    else if (stb.clrIrq)                   statNext = irqStatQ & ~wrData;
    else                                   statNext = irqStatQ;
  end
  assign statNextNz = |statNext;

  // Storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      kbdAddrQ  <= '0;
      powerQ    <= '0;
      contrastQ <= '0;
      brightQ   <= '0;
      kbdScanQ  <= '0;
      edgeQ     <= '0;
      maskQ     <= '0;
      irqStatQ  <= '0;
      funcQ     <= '0;
      flagQ     <= '0;
      ptrQ      <= '0;
      rdDataQ   <= '0;
    end else begin
      if (stb.wrCtrl)     ctrlQ     <= wrData;
      if (stb.wrKbdAddr)  kbdAddrQ  <= wrData;
      if (stb.wrPower)    powerQ    <= wrData;
      if (stb.wrContrast) contrastQ <= wrData;
      if (stb.wrBright)   brightQ   <= wrData;
      if (stb.wrKbdScan)  kbdScanQ  <= wrData;
      if (stb.wrEdge)     edgeQ     <= wrData;
      if (stb.wrMask)     maskQ     <= wrData;
      if (stb.wrFunc)     funcQ     <= wrData;
      irqStatQ <= statNext;
      if (stb.wrFunc && (wrData == CODE_A || wrData == CODE_B)) flagQ <= FLAG_VAL;
      else if (stb.popFlag)                                     flagQ <= '0;
      if (stb.popStream) ptrQ <= PTR_W'(ptrQ + PTR_W'(2));
      if (stb.rdCap)     rdDataQ <= rdValue;
    end
  end

  // Read-back selection
  always_comb begin
    case (int'(addr))
      ADR_KBDADDR: rdValue = kbdAddrQ;
      ADR_POWER:   rdValue = powerQ;
      ADR_CONTRST: rdValue = contrastQ;
      ADR_BRIGHT:  rdValue = brightQ;
      ADR_KBDSCAN: rdValue = kbdScanQ;
      ADR_EDGE:    rdValue = edgeQ;
      ADR_MASK:    rdValue = maskQ;
      ADR_IRQSTAT: rdValue = irqStatQ;
      ADR_FNFLAG:  rdValue = flagQ;
      ADR_FNCODE:  rdValue = funcQ;
      ADR_STREAM:  rdValue = {cfgMem[ptrHi], cfgMem[ptrQ]};
      default:     rdValue = '0;
    endcase
  end

  assign rdData = rdDataQ;

endmodule

// File: rtl/cmpn_regbank.sv
module cmpn_regbank
  import cmpn_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          MEM_BYTES = 16,
  parameter logic [15:0] LOAD_MASK = 16'h6000,
  parameter logic [15:0] CODE_A    = 16'd4,
  parameter logic [15:0] CODE_B    = 16'd6,
  parameter logic [15:0] FLAG_VAL  = 16'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  output logic              irqOut
);

  localparam int PTR_W = $clog2(MEM_BYTES);

  strobes_t         stb;
  logic             statNextNz;
  logic [15:0]      irqStatQ, maskQ, flagQ, ctrlQ;
  logic [PTR_W-1:0] ptrQ;

  cmpn_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .statNextNz(statNextNz), .stb(stb), .irqOut(irqOut)
  );

  cmpn_dp #(
    .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .LOAD_MASK(LOAD_MASK),
    .CODE_A(CODE_A), .CODE_B(CODE_B), .FLAG_VAL(FLAG_VAL)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .rdData(rdData), .statNextNz(statNextNz), .irqStatQ(irqStatQ),
    .maskQ(maskQ), .flagQ(flagQ), .ctrlQ(ctrlQ), .ptrQ(ptrQ)
  );

endmodule

// File: rtl/cmpn_regbank_chk.sv
module cmpn_regbank_chk #(
  parameter int          ADDR_W    = 4,
  parameter int          MEM_BYTES = 16,
  parameter logic [15:0] LOAD_MASK = 16'h6000
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         tick,
  input logic                         wrEn,
  input logic                         rdEn,
  input logic [ADDR_W-1:0]            addr,
  input logic [15:0]                  wrData,
  input logic [15:0]                  rdData,
  input logic                         irqOut,
  input logic [15:0]                  irqStatQ,
  input logic [15:0]                  maskQ,
  input logic [15:0]                  flagQ,
  input logic [15:0]                  ctrlQ,
  input logic [$clog2(MEM_BYTES)-1:0] ptrQ
);

  localparam int PTR_W = $clog2(MEM_BYTES);

  p_ctrl_store_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(addr) == 0) |=> (ctrlQ == $past(wrData)));

  p_ctrl_read_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(addr) == 0) |=> (rdData == 16'h0));

  p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(addr) == 8 && !tick) |=> (irqStatQ == ($past(irqStatQ) & ~$past(wrData))));

  p_flag_read_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(addr) == 9 && !(wrEn && int'(addr) == 10)) |=> (flagQ == 16'h0));

  p_stream_advance_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(addr) == 11) |=> (ptrQ == PTR_W'($past(ptrQ) + PTR_W'(2))));

  p_tick_reload_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tick && (maskQ & LOAD_MASK) != 16'h0) |=> (irqStatQ == $past(maskQ)));

  p_pin_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(irqOut));

  p_pin_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (tick && irqOut) |=> !irqOut);

  p_unknown_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(addr) >= 12) |=> (rdData == 16'h0));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind cmpn_regbank cmpn_regbank_chk #(
  .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .LOAD_MASK(LOAD_MASK)
) chk_i (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
  .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut),
  .irqStatQ(irqStatQ), .maskQ(maskQ), .flagQ(flagQ), .ctrlQ(ctrlQ),
  .ptrQ(ptrQ)
);

// File: tb/cmpn_regbank_tb_top.sv
module cmpn_regbank_tb_top;

  localparam int TB_BYTES = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmpn_regbank #(.ADDR_W(4), .MEM_BYTES(TB_BYTES)) dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  // Table vectors: {address, write value, expected read}
  localparam logic [35:0] VEC [10] = '{
    {4'd1,  16'hA5C3, 16'hA5C3},  // R2 keyboard address
    {4'd2,  16'h0F0F, 16'h0F0F},  // R2 power
    {4'd3,  16'h1234, 16'h1234},  // R2 contrast
    {4'd4,  16'hFFFF, 16'hFFFF},  // R2 brightness
    {4'd5,  16'h8001, 16'h8001},  // R2 keyboard scan
    {4'd6,  16'h00FF, 16'h00FF},  // R2 edge select
    {4'd7,  16'h0011, 16'h0011},  // R2 mask, no reload bit
    {4'd0,  16'hBEEF, 16'h0000},  // R3 control reads as zero
    {4'd13, 16'h7777, 16'h0000},  // R11 unknown address
    {4'd10, 16'h0003, 16'h0003}   // R6 function code readback
  };

  function automatic string reqOf(input logic [3:0] a);
    if (a == 4'd0)  return "R3";
    if (a >= 4'd12) return "R11";
    if (a == 4'd10) return "R6";
    return "R2";
  endfunction

  function automatic logic [7:0] expByte(input int i);
    return 8'((i * 29 + 53) % 256);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic doTick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] v, held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1", "rdData after reset", rdData, 16'h0);
    check("R1", "irqOut after reset", 16'(irqOut), 16'h0);
    doRead(4'd8, v);  check("R1", "irq status after reset", v, 16'h0);
    doRead(4'd7, v);  check("R1", "mask after reset", v, 16'h0);
    doRead(4'd9, v);  check("R1", "flag after reset", v, 16'h0);
    doRead(4'd11, v); check("R1", "stream first pair after reset",
                            v, {expByte(1), expByte(0)});

    // Table walk
    for (int i = 0; i < 10; i++) begin
      doWrite(VEC[i][35:32], VEC[i][31:16]);
      doRead(VEC[i][35:32], v);
      check(reqOf(VEC[i][35:32]), $sformatf("table[%0d]", i), v, VEC[i][15:0]);
    end
    // R11: unknown write changed no known register
    doRead(4'd3, v); check("R11", "contrast after unknown write", v, 16'h1234);

    // R9: mask without reload bits leaves status alone
    doTick();
    doRead(4'd8, v); check("R9", "no reload without 0x6000 bits", v, 16'h0);
    check("R10", "pin low with zero status", 16'(irqOut), 16'h0);

    // R9/R10 reload and toggling
    doWrite(4'd7, 16'h6005);
    doTick();
    check("R10", "pin rises on first pending tick", 16'(irqOut), 16'h1);
    doRead(4'd8, v); check("R9", "status loaded from mask", v, 16'h6005);
    doWrite(4'd7, 16'h0000);
    repeat (3) @(negedge clk);
    check("R10", "pin holds between ticks", 16'(irqOut), 16'h1);

    // R4 write-one-to-clear
    doWrite(4'd8, 16'h0004);
    doRead(4'd8, v); check("R4", "clear one bit", v, 16'h6001);
    doTick();
    check("R10", "pin falls on next tick", 16'(irqOut), 16'h0);
    doTick();
    check("R10", "pin rises again", 16'(irqOut), 16'h1);
    doWrite(4'd8, 16'h6001);
    doRead(4'd8, v); check("R4", "clear remaining bits", v, 16'h0);
    doTick();
    check("R10", "pin low once status is zero", 16'(irqOut), 16'h0);
    doTick();
    check("R10", "pin stays low", 16'(irqOut), 16'h0);

    // R9 reload beats same-edge clear
    doWrite(4'd7, 16'h2000);
    @(negedge clk);
    addr = 4'd8; wrData = 16'h2000; wrEn = 1'b1; tick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
    doRead(4'd8, v); check("R9", "reload wins over clear", v, 16'h2000);
    doWrite(4'd7, 16'h0000);
    doWrite(4'd8, 16'hFFFF);

    // R5/R6 function flag
    doWrite(4'd10, 16'd4);
    doRead(4'd9, v);  check("R6", "code 4 sets flag", v, 16'h2);
    doRead(4'd9, v);  check("R5", "flag cleared by read", v, 16'h0);
    doWrite(4'd10, 16'd6);
    doWrite(4'd9, 16'h0055);
    doRead(4'd9, v);  check("R5", "write to flag ignored", v, 16'h2);
    doRead(4'd10, v); check("R6", "code stored", v, 16'd6);
    doWrite(4'd10, 16'd5);
    doRead(4'd9, v);  check("R6", "code 5 leaves flag clear", v, 16'h0);
    doWrite(4'd9, 16'h0055);
    doRead(4'd9, v);  check("R5", "write cannot set flag", v, 16'h0);

    // R7/R8 stream (first pair already consumed at reset check)
    for (int k = 1; k < TB_BYTES / 2; k++) begin
      doRead(4'd11, v);
      check("R7", $sformatf("stream pair %0d", k), v,
            {expByte(2 * k + 1), expByte(2 * k)});
    end
    doRead(4'd11, v); check("R8", "stream wraps to start", v, {expByte(1), expByte(0)});
    doRead(4'd11, v); check("R8", "stream continues after wrap", v, {expByte(3), expByte(2)});

    // R12 read data holds
    doRead(4'd4, held);
    doWrite(4'd4, 16'h0101);
    repeat (2) @(negedge clk);
    check("R12", "rdData held across write", rdData, held);
    doRead(4'd4, v); check("R2", "brightness rewrite", v, 16'h0101);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule